// File: doc/BRIEF.md
# Directory Home-Node Coherence Controller

This block is the home side of a directory coherence scheme for a machine whose nodes talk over a message network instead of a shared bus. For every memory block it owns, it keeps the block data and a directory entry made of one presence bit per node and a dirty flag. Read-miss and write-miss messages arrive tagged with the requesting node's ID. The home answers with data, with the identity of the node that holds a modified copy, or with the list of sharers that the requester must invalidate itself. When a modified copy must be taken back from its owner, the home asks the owner for it.

Each block runs its own four-state machine. `BS_CLEAN` means memory is current, and any set presence bits mark read-only sharers. `BS_OWNED` means exactly one node holds a modified copy. `BS_WAIT_REV` means the home has told a reader who the owner is and now waits for the owner's revision message. `BS_WAIT_XFER` means the home has sent an invalidating fetch to the owner and waits for the data.

The transitions are:
- CLEAN to CLEAN on a read miss.
- CLEAN to OWNED on a write miss.
- OWNED to WAIT_REV on a read miss.
- OWNED to WAIT_XFER on a write miss.
- WAIT_REV to CLEAN on the owner's revision.
- WAIT_XFER to OWNED on the owner's data.

While a block waits, any new miss to that block is refused with a NACK. Each accepted message produces at most one outbound message, registered one cycle later.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every block is CLEAN with no presence bits set and data zero, and `out_valid` is low.
- R2: A read miss (type 0) from node i to a CLEAN block yields, one cycle later, a data message (type 2) to node i carrying the stored block, with aux 0 and vec 0. Presence bit i is then set.
- R3: A read miss from node i to an OWNED block yields an owner message (type 3) to node i with aux equal to the owner's ID. The block enters WAIT_REV with i remembered as the pending requester.
- R4: In WAIT_REV, a revision (type 6) from the owner writes its data into memory and produces no outbound message. The block returns to CLEAN with presence set for both the owner and the pending requester.
- R5: A write miss (type 1) from node i to a CLEAN block yields a data message to i carrying the block. Its vec field holds the previous presence vector with bit i cleared, with node 0 in the LSB. Afterwards only bit i is present and the block is OWNED.
- R6: A write miss from node i to an OWNED block yields an invalidating fetch (type 5) to the owner with aux = i. The block enters WAIT_XFER.
- R7: In WAIT_XFER, a data message (type 2) from the owner is forwarded as a data message to the pending requester, with the owner's data and vec 0. The requester becomes the sole owner.
- R8: A read or write miss to a block in WAIT_REV or WAIT_XFER gets a NACK (type 7) to the sender, and the entry is unchanged.
- R9: Whenever a block is not CLEAN, exactly one presence bit is set.
- R10: The following are ignored, with no outbound message and no change to the entry or the data:
  - a revision or data message that does not come from the current owner of a waiting block;
  - a revision or data message to a block that is not in the matching wait state;
  - a message of type 4, 5 or 7;
  - a cycle without `in_valid`.
- R11: Blocks are independent. A block waiting on its owner does not affect misses to other blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound message present this cycle |
| in_type | input | 3 | Inbound message type |
| in_src | input | ID_W | Sending node ID |
| in_addr | input | ADDR_W | Block index |
| in_data | input | DATA_W | Block data (revision, owner data) |
| out_valid | output | 1 | Outbound message present |
| out_type | output | 3 | Outbound message type |
| out_dst | output | ID_W | Destination node ID |
| out_aux | output | ID_W | Owner ID (type 3) or requester ID (type 5), else 0 |
| out_addr | output | ADDR_W | Block index the message concerns |
| out_data | output | DATA_W | Block data for type 2, else 0 |
| out_vec | output | NODES | Sharers to invalidate for a clean write miss, else 0 |

## Verification
The bench builds the block with four nodes, eight blocks and 16-bit data. Four nodes let a sharer vector carry several bits at once, including node 0 in the LSB and node 3 at the top. They also allow owners, requesters and stray senders to all be distinct nodes. Eight blocks let one block sit in a wait state while misses to another block proceed, which exercises the refusal path and block independence in the same run.

// File: rtl/hn_pkg.sv
package hn_pkg;

    typedef enum logic [2:0] {
        MSG_RD_MISS   = 3'd0,
        MSG_WR_MISS   = 3'd1,
        MSG_DATA      = 3'd2,
        MSG_OWNER     = 3'd3,
        MSG_FETCH     = 3'd4,
        MSG_FETCH_INV = 3'd5,
        MSG_REVISION  = 3'd6,
        MSG_NACK      = 3'd7
    } msg_e;

    typedef enum logic [1:0] {
        BS_CLEAN     = 2'd0,
        BS_OWNED     = 2'd1,
        BS_WAIT_REV  = 2'd2,
        BS_WAIT_XFER = 2'd3
    } blk_e;

endpackage

// File: rtl/hn_dir_store.sv
module hn_dir_store
    import hn_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    localparam int ID_W   = $clog2(NODES),
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output blk_e              rd_state,
    output logic [NODES-1:0]  rd_pres,
    output logic [ID_W-1:0]   rd_pend,
    input  logic              we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  blk_e              wr_state,
    input  logic [NODES-1:0]  wr_pres,
    input  logic [ID_W-1:0]   wr_pend
);

    blk_e             state_q [BLOCKS];
    logic [NODES-1:0] pres_q  [BLOCKS];
    logic [ID_W-1:0]  pend_q  [BLOCKS];

    // State register: one entry per block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) begin
                state_q[b] <= BS_CLEAN;
                pres_q[b]  <= '0;
                pend_q[b]  <= '0;
            end
        end else if (we) begin
            state_q[wr_addr] <= wr_state;
            pres_q[wr_addr]  <= wr_pres;
            pend_q[wr_addr]  <= wr_pend;
        end
    end

    assign rd_state = state_q[rd_addr];
    assign rd_pres  = pres_q[rd_addr];
    assign rd_pend  = pend_q[rd_addr];

    // R9
    dirty_write_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_state != BS_CLEAN) |-> ($countones(wr_pres) == 1));

    // R9
    dirty_stored_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state != BS_CLEAN) |-> ($countones(rd_pres) == 1));

endmodule

// File: rtl/hn_data_store.sv
module hn_data_store #(
    parameter int BLOCKS = 8,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] mem_q [BLOCKS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) mem_q[b] <= '0;
        end else if (we) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/hn_protocol.sv
module hn_protocol
    import hn_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 32,
    localparam int ID_W   = $clog2(NODES),
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input  logic              in_valid,
    input  msg_e              in_msg,
    input  logic [ID_W-1:0]   in_src,
    input  logic [DATA_W-1:0] in_data,
    input  blk_e              cur_state,
    input  logic [NODES-1:0]  cur_pres,
    input  logic [ID_W-1:0]   cur_pend,
    input  logic [DATA_W-1:0] mem_data,
    output logic              dir_we,
    output blk_e              nx_state,
    output logic [NODES-1:0]  nx_pres,
    output logic [ID_W-1:0]   nx_pend,
    output logic              mem_we,
    output logic              rep_valid,
    output msg_e              rep_type,
    output logic [ID_W-1:0]   rep_dst,
    output logic [ID_W-1:0]   rep_aux,
    output logic [DATA_W-1:0] rep_data,
    output logic [NODES-1:0]  rep_vec
);

    function automatic logic [ID_W-1:0] owner_of(input logic [NODES-1:0] v);
        owner_of = '0;
        for (int k = NODES - 1; k >= 0; k--) begin
            if (v[k]) owner_of = ID_W'(k);
        end
    endfunction

    logic [NODES-1:0] src_bit;
    logic [NODES-1:0] pend_bit;
    logic [ID_W-1:0]  owner;
    logic             is_miss;

    always_comb begin
        src_bit           = '0;
        src_bit[in_src]   = 1'b1;
        pend_bit          = '0;
        pend_bit[cur_pend] = 1'b1;
        owner             = owner_of(cur_pres);
        is_miss           = (in_msg == MSG_RD_MISS) || (in_msg == MSG_WR_MISS);
    end

    // Next-entry and reply decision per block state.
    always_comb begin
        dir_we    = 1'b0;
        nx_state  = cur_state;
        nx_pres   = cur_pres;
        nx_pend   = cur_pend;
        mem_we    = 1'b0;
        rep_valid = 1'b0;
        rep_type  = MSG_NACK;
        rep_dst   = in_src;
        rep_aux   = '0;
        rep_data  = '0;
        rep_vec   = '0;
        if (in_valid) begin
            unique case (cur_state)
                BS_CLEAN: begin
                    if (in_msg == MSG_RD_MISS) begin
                        rep_valid = 1'b1;
                        rep_type  = MSG_DATA;
                        rep_data  = mem_data;
                        dir_we    = 1'b1;
                        nx_pres   = cur_pres | src_bit;
                    end else if (in_msg == MSG_WR_MISS) begin
                        rep_valid = 1'b1;
                        rep_type  = MSG_DATA;
                        rep_data  = mem_data;
                        rep_vec   = cur_pres & ~src_bit;
                        dir_we    = 1'b1;
                        nx_state  = BS_OWNED;
                        nx_pres   = src_bit;
                    end
                end
                BS_OWNED: begin
                    if (in_msg == MSG_RD_MISS) begin
                        rep_valid = 1'b1;
                        rep_type  = MSG_OWNER;
                        rep_aux   = owner;
                        dir_we    = 1'b1;
                        nx_state  = BS_WAIT_REV;
                        nx_pend   = in_src;
                    end else if (in_msg == MSG_WR_MISS) begin
                        rep_valid = 1'b1;
                        rep_type  = MSG_FETCH_INV;
                        rep_dst   = owner;
                        rep_aux   = in_src;
                        dir_we    = 1'b1;
                        nx_state  = BS_WAIT_XFER;
                        nx_pend   = in_src;
                    end
                end
                BS_WAIT_REV: begin
                    if (is_miss) begin
                        rep_valid = 1'b1;
                        rep_type  = MSG_NACK;
                    end else if (in_msg == MSG_REVISION && in_src == owner) begin
                        mem_we   = 1'b1;
                        dir_we   = 1'b1;
                        nx_state = BS_CLEAN;
                        nx_pres  = cur_pres | pend_bit;
                    end
                end
                BS_WAIT_XFER: begin
                    if (is_miss) begin
                        rep_valid = 1'b1;
                        rep_type  = MSG_NACK;
                    end else if (in_msg == MSG_DATA && in_src == owner) begin
                        rep_valid = 1'b1;
                        rep_type  = MSG_DATA;
                        rep_dst   = cur_pend;
                        rep_data  = in_data;
                        dir_we    = 1'b1;
                        nx_state  = BS_OWNED;
                        nx_pres   = pend_bit;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
    import hn_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 32,
    localparam int ID_W   = $clog2(NODES),
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_type,
    input  logic [ID_W-1:0]   in_src,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [2:0]        out_type,
    output logic [ID_W-1:0]   out_dst,
    output logic [ID_W-1:0]   out_aux,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [NODES-1:0]  out_vec
);

    msg_e              in_msg;
    blk_e              cur_state;
    logic [NODES-1:0]  cur_pres;
    logic [ID_W-1:0]   cur_pend;
    logic [DATA_W-1:0] mem_data;
    logic              dir_we;
    blk_e              nx_state;
    logic [NODES-1:0]  nx_pres;
    logic [ID_W-1:0]   nx_pend;
    logic              mem_we;
    logic              rep_valid;
    msg_e              rep_type;
    logic [ID_W-1:0]   rep_dst;
    logic [ID_W-1:0]   rep_aux;
    logic [DATA_W-1:0] rep_data;
    logic [NODES-1:0]  rep_vec;

    assign in_msg = msg_e'(in_type);

    hn_dir_store #(.NODES(NODES), .BLOCKS(BLOCKS)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (in_addr),
        .rd_state (cur_state),
        .rd_pres  (cur_pres),
        .rd_pend  (cur_pend),
        .we       (dir_we),
        .wr_addr  (in_addr),
        .wr_state (nx_state),
        .wr_pres  (nx_pres),
        .wr_pend  (nx_pend)
    );

    hn_data_store #(.BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (in_addr),
        .rd_data (mem_data),
        .we      (mem_we),
        .wr_addr (in_addr),
        .wr_data (in_data)
    );

    hn_protocol #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_proto (
        .in_valid  (in_valid),
        .in_msg    (in_msg),
        .in_src    (in_src),
        .in_data   (in_data),
        .cur_state (cur_state),
        .cur_pres  (cur_pres),
        .cur_pend  (cur_pend),
        .mem_data  (mem_data),
        .dir_we    (dir_we),
        .nx_state  (nx_state),
        .nx_pres   (nx_pres),
        .nx_pend   (nx_pend),
        .mem_we    (mem_we),
        .rep_valid (rep_valid),
        .rep_type  (rep_type),
        .rep_dst   (rep_dst),
        .rep_aux   (rep_aux),
        .rep_data  (rep_data),
        .rep_vec   (rep_vec)
    );

    // Output process: registered reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_type  <= '0;
            out_dst   <= '0;
            out_aux   <= '0;
            out_addr  <= '0;
            out_data  <= '0;
            out_vec   <= '0;
        end else begin
            out_valid <= rep_valid;
            out_type  <= rep_valid ? rep_type : 3'd0;
            out_dst   <= rep_valid ? rep_dst  : '0;
            out_aux   <= rep_valid ? rep_aux  : '0;
            out_addr  <= rep_valid ? in_addr  : '0;
            out_data  <= rep_valid ? rep_data : '0;
            out_vec   <= rep_valid ? rep_vec  : '0;
        end
    end

    // R8
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_msg == MSG_RD_MISS || in_msg == MSG_WR_MISS) &&
         (cur_state == BS_WAIT_REV || cur_state == BS_WAIT_XFER))
        |=> (out_valid && out_type == MSG_NACK && out_dst == $past(in_src)));

    // R4
    revision_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_msg == MSG_REVISION) |=> !out_valid);

    // R10
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    clean_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_msg == MSG_RD_MISS && cur_state == BS_CLEAN)
        |=> (out_valid && out_type == MSG_DATA && out_data == $past(mem_data)));

endmodule

// File: tb/tb_home_dir_ctrl.sv
module tb_home_dir_ctrl;

    localparam int NODES  = 4;
    localparam int BLOCKS = 8;
    localparam int DATA_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_type = '0;
    logic [1:0]  in_src = '0;
    logic [2:0]  in_addr = '0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [2:0]  out_type;
    logic [1:0]  out_dst;
    logic [1:0]  out_aux;
    logic [2:0]  out_addr;
    logic [15:0] out_data;
    logic [3:0]  out_vec;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Behavioural reference state: 0 clean, 1 owned, 2 wait revision, 3 wait transfer.
    int m_st   [BLOCKS];
    int m_pres [BLOCKS];
    int m_pend [BLOCKS];
    int m_mem  [BLOCKS];

    int ev, et, ed, ea, eaddr, edata, evec;

    always #2 clk = ~clk;

    home_dir_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type),
        .in_src(in_src), .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid), .out_type(out_type), .out_dst(out_dst),
        .out_aux(out_aux), .out_addr(out_addr), .out_data(out_data),
        .out_vec(out_vec)
    );

    function automatic int owner_of(int v);
        for (int k = 0; k < NODES; k++) if (v[k]) return k;
        return 0;
    endfunction

    task automatic model(int t, int src, int a, int dat);
        int own;
        own = owner_of(m_pres[a]);
        ev = 0; et = 0; ed = 0; ea = 0; eaddr = 0; edata = 0; evec = 0;
        if (m_st[a] == 0) begin
            if (t == 0 || t == 1) begin
                ev = 1; et = 2; ed = src; eaddr = a; edata = m_mem[a];
                if (t == 0) m_pres[a] = m_pres[a] | (1 << src);
                else begin
                    evec = m_pres[a] & ~(1 << src);
                    m_pres[a] = 1 << src;
                    m_st[a] = 1;
                end
            end
        end else if (m_st[a] == 1) begin
            if (t == 0) begin
                ev = 1; et = 3; ed = src; ea = own; eaddr = a;
                m_st[a] = 2; m_pend[a] = src;
            end else if (t == 1) begin
                ev = 1; et = 5; ed = own; ea = src; eaddr = a;
                m_st[a] = 3; m_pend[a] = src;
            end
        end else begin
            if (t == 0 || t == 1) begin
                ev = 1; et = 7; ed = src; eaddr = a;
            end else if (m_st[a] == 2 && t == 6 && src == own) begin
                m_mem[a] = dat;
                m_pres[a] = m_pres[a] | (1 << m_pend[a]);
                m_st[a] = 0;
            end else if (m_st[a] == 3 && t == 2 && src == own) begin
                ev = 1; et = 2; ed = m_pend[a]; eaddr = a; edata = dat;
                m_pres[a] = 1 << m_pend[a];
                m_st[a] = 1;
            end
        end
    endtask

    task automatic compare(string tag);
        bit bad;
        checks++;
        bad = (out_valid !== ev[0]);
        if (ev != 0) begin
            bad = bad || (out_type !== et[2:0]) || (out_dst !== ed[1:0]) ||
                  (out_aux !== ea[1:0]) || (out_addr !== eaddr[2:0]) ||
                  (out_data !== edata[15:0]) || (out_vec !== evec[3:0]);
        end
        if (bad) begin
            fails++;
            $display("FAIL %s: got v=%0d t=%0d dst=%0d aux=%0d addr=%0d data=%h vec=%b expected v=%0d t=%0d dst=%0d aux=%0d addr=%0d data=%h vec=%b",
                     tag, out_valid, out_type, out_dst, out_aux, out_addr, out_data, out_vec,
                     ev, et, ed, ea, eaddr, edata[15:0], evec[3:0]);
        end
        // R9: model invariant after each update
        for (int b = 0; b < BLOCKS; b++) begin
            if (m_st[b] != 0 && $countones(m_pres[b]) != 1) begin
                fails++;
                $display("FAIL R9 block %0d: presence=%b expected one bit", b, m_pres[b][3:0]);
            end
        end
    endtask

    task automatic send(int t, int src, int a, int dat, string tag);
        in_valid = 1'b1;
        in_type  = 3'(t);
        in_src   = 2'(src);
        in_addr  = 3'(a);
        in_data  = 16'(dat);
        model(t, src, a, dat);
        @(negedge clk);
        in_valid = 1'b0;
        compare(tag);
    endtask

    task automatic idle(string tag);
        ev = 0;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        for (int b = 0; b < BLOCKS; b++) begin
            m_st[b] = 0; m_pres[b] = 0; m_pend[b] = 0; m_mem[b] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ev = 0;
        compare("R1 reset out_valid low");
        idle("R1 idle after reset");

        send(0, 1, 2, 0, "R2 read clean n1");
        send(0, 3, 2, 0, "R2 read clean n3");
        send(0, 0, 2, 0, "R2 read clean n0");
        send(1, 2, 2, 0, "R5 write clean sharers 0,1,3");
        send(0, 1, 2, 0, "R3 read owned -> owner id 2");
        send(0, 3, 2, 0, "R8 read busy nack");
        send(1, 0, 2, 0, "R8 write busy nack");
        send(0, 2, 5, 0, "R11 other block during wait");
        send(6, 3, 2, 16'h1111, "R10 revision from non-owner ignored");
        send(6, 2, 2, 16'hBEEF, "R4 revision from owner silent");
        send(0, 0, 2, 0, "R4 read gets revised data");
        send(1, 1, 2, 0, "R5 write clean by sharer vec 0,2");
        send(1, 3, 2, 0, "R6 write owned -> fetch-inv to 1");
        send(0, 0, 2, 0, "R8 read nack in wait xfer");
        send(1, 3, 5, 0, "R11 write other block during wait vec 2");
        send(2, 0, 2, 16'h5555, "R10 data from non-owner ignored");
        send(2, 1, 2, 16'h1234, "R7 owner data forwarded to 3");
        send(0, 0, 2, 0, "R7 new owner is 3");
        send(6, 3, 2, 16'hCAFE, "R4 second revision");
        send(0, 1, 2, 0, "R4 data after second revision");
        send(4, 1, 3, 0, "R10 type 4 ignored");
        send(7, 2, 3, 0, "R10 type 7 ignored");
        send(5, 0, 3, 0, "R10 type 5 ignored");
        send(6, 1, 3, 16'h7777, "R10 revision to clean ignored");
        send(2, 1, 3, 16'h7777, "R10 data to clean ignored");
        send(0, 2, 3, 0, "R10 block 3 still zero");
        send(0, 3, 7, 0, "R2 read blk7 n3");
        send(1, 0, 7, 0, "R5 write n0 vec bit3");
        send(1, 0, 7, 0, "R6 owner re-miss fetch-inv to self");
        send(2, 0, 7, 16'h0A0A, "R7 forwarded to 0");
        idle("R10 idle quiet");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule